// File: doc/BRIEF.md
# External Interrupt Trigger Mode Unit

This block conditions a set of external interrupt pins (eight by default) before they reach an interrupt controller. Each pin is first brought into the local clock domain through a two-flop synchroniser. It is then qualified by its own 2-bit trigger mode, which selects active-low level, active-high level, rising edge or falling edge. The result is one request line per pin. In a level mode the line is held while the pin sits at its active polarity. In an edge mode the line gives a single-cycle pulse on the chosen transition.

The modes live in byte-wide mode registers on a simple write/read register bus. Each byte holds the modes of four consecutive pins. Reads are combinational from the current register contents.

A write that changes a pin's mode is handled cleanly: the request computed under the old mode is dropped, and the edge history is re-primed. The reconfiguration therefore never appears downstream as an interrupt. Request latching and priority are left to the controller that consumes the lines.

Top module: `ext_irq_trigger`

## Requirements
- R1: While reset is asserted and right after it, every request line is 0 and every pin's mode is 3 (falling edge), so register offset 0 reads 0xFF.
- R2: A write to offset k sets the mode of pin 4k+i from bits [2i+1:2i] of the write data. A read of offset k returns those four 2-bit modes packed the same way.
- R3: Mode 0 (active low): the pin's request is 1 exactly while the synchronised pin is 0. A pin change shows on its request line in the third cycle after the clock edge that first samples it.
- R4: Mode 1 (active high): the pin's request is 1 exactly while the synchronised pin is 1, with the same three-cycle latency.
- R5: Mode 2 (rising edge): each 0-to-1 transition of the synchronised pin gives a request pulse exactly one cycle wide. Nothing else gives a pulse.
- R6: Mode 3 (falling edge): each 1-to-0 transition of the synchronised pin gives a one-cycle request pulse. Nothing else gives a pulse.
- R7: Offsets at or above NUM_PINS/4 read as 0x00, and writes to them change no mode.
- R8: In the cycle after a write that changes a pin's mode, that pin's request is 0. A write that leaves a pin's mode unchanged has no effect on its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one byte per cycle |
| bus_addr | input | ADDR_W | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| req_out | output | NUM_PINS | Per-pin request, level or one-cycle pulse |

## Verification
The bench aims at a mode being rewritten while the pin already sits at a level the new mode would treat as active or as a fresh edge. A design that does not re-prime would emit a phantom pulse or a stray level cycle there. It also toggles pins on consecutive cycles in edge modes; a detector that stretches or merges pulses would show a two-cycle request or lose a transition. Reads and writes at offsets past the last register are mixed in: a loose address decode would either alias them onto a real register or return stale bytes. Packing is checked on the upper register, where a pin-index slip would move modes onto the wrong pin.

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] req_out
);
  localparam int NREG = NUM_PINS / 4;

  logic [NUM_PINS-1:0]   sync_a, sync_b, last_b, req_q, hit, chg;
  logic [2*NUM_PINS-1:0] mode_flat;
  logic [NREG-1:0]       wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      last_b <= '0;
      req_q  <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      last_b <= sync_b;
      req_q  <= hit & ~chg;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign wr_sel[k] = bus_wr && (bus_addr == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_flat[8*k +: 8] <= 8'hFF;
      else if (wr_sel[k]) mode_flat[8*k +: 8] <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int K = i / 4;
    localparam int J = i % 4;
    logic [1:0] m;
    assign m      = mode_flat[2*i +: 2];
    assign chg[i] = wr_sel[K] && (bus_wdata[2*J +: 2] != m);
    always_comb begin
      case (m)
        2'd0:    hit[i] = ~sync_b[i];
        2'd1:    hit[i] =  sync_b[i];
        2'd2:    hit[i] =  sync_b[i] & ~last_b[i];
        default: hit[i] = ~sync_b[i] &  last_b[i];
      endcase
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (bus_addr == ADDR_W'(k)) bus_rdata = mode_flat[8*k +: 8];
  end

  assign req_out = req_q;
endmodule

module ext_irq_trigger_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic [NUM_PINS-1:0]   req_out,
  input logic [2*NUM_PINS-1:0] mode_flat
);
  localparam int NREG = NUM_PINS / 4;

  a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> req_out == '0);

  a_r7_high_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= NREG) |-> bus_rdata == 8'h00);

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) ##1 (bus_addr == '0) |-> bus_rdata == $past(bus_wdata));

  a_r8_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[1:0] != mode_flat[1:0]) |=> !req_out[0]);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_p
    a_r5_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flat[2*i+1] && req_out[i]) |=> !req_out[i]);
  end
endmodule

bind ext_irq_trigger ext_irq_trigger_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_out(req_out),
  .mode_flat(mode_flat)
);

// File: tb/test_ext_irq_trigger.sv
module test_ext_irq_trigger;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam time CLK_P = 20ns;

  logic          clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic [N-1:0]  pin_in = '0, req_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [2*N-1:0] m_mode;
  logic [N-1:0]   h1, h2, h3, h4;
  bit             p_wr;
  logic [AW-1:0]  p_addr;
  logic [7:0]     p_data;

  ext_irq_trigger #(.NUM_PINS(N), .ADDR_W(AW)) i_ext_irq_trigger (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .req_out(req_out));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic exp_req(input logic [1:0] m, input logic cur, input logic prv);
    case (m)
      2'd0: return !cur;
      2'd1: return cur;
      2'd2: return cur && !prv;
      default: return !cur && prv;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] pins, input bit wr,
                      input logic [AW-1:0] addr, input logic [7:0] data);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      logic [1:0] mo;
      logic       e;
      bit         sup;
      mo  = m_mode[2*i +: 2];
      sup = p_wr && (int'(p_addr) == i/4) && (p_data[2*(i%4) +: 2] != mo);
      e   = sup ? 1'b0 : exp_req(mo, h3[i], h4[i]);
      check(sup ? "R8" : mode_tag(mo), {7'd0, req_out[i]}, {7'd0, e});
    end
    if (p_wr && int'(p_addr) < N/4) m_mode[8*p_addr +: 8] = p_data;
    check((int'(p_addr) < N/4) ? "R2" : "R7", bus_rdata,
          (int'(p_addr) < N/4) ? m_mode[8*p_addr +: 8] : 8'h00);
    h4 = h3; h3 = h2; h2 = h1; h1 = pins;
    pin_in = pins; bus_wr = wr; bus_addr = addr; bus_wdata = data;
    p_wr = wr; p_addr = addr; p_data = data;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pins;
    void'($urandom(32'd20240517));
    m_mode = {2*N{1'b1}};
    h1 = '0; h2 = '0; h3 = '0; h4 = '0;
    p_wr = 0; p_addr = '0; p_data = '0;
    repeat (3) @(negedge clk);
    check("R1", {7'd0, |req_out}, 8'h00);
    check("R1", bus_rdata, 8'hFF);
    rst_n = 1;
    // directed: one mode per pin, upper register packed the same way
    step('0, 1, 3'd0, 8'b11_10_01_00);
    step('0, 1, 3'd1, 8'b00_01_10_11);
    step('0, 0, 3'd1, 0);
    for (int c = 0; c < 6; c++) step('0, 0, 3'd0, 0);
    step('1, 0, 3'd0, 0);
    for (int c = 0; c < 5; c++) step('1, 0, 3'd1, 0);
    step('0, 0, 3'd0, 0);
    step('1, 0, 3'd0, 0);
    step('0, 0, 3'd0, 0);
    for (int c = 0; c < 5; c++) step('0, 0, 3'd0, 0);
    // R7: out-of-range write and read
    step('0, 1, 3'd5, 8'h00);
    step('0, 0, 3'd5, 0);
    step('0, 0, 3'd0, 0);
    // R8: pins high, switch high-level to rising, then same-value rewrite
    step('1, 1, 3'd0, 8'h55);
    for (int c = 0; c < 5; c++) step('1, 0, 3'd0, 0);
    step('1, 1, 3'd0, 8'hAA);
    step('1, 1, 3'd0, 8'hAA);
    for (int c = 0; c < 4; c++) step('1, 0, 3'd0, 0);
    step('1, 1, 3'd0, 8'h00);
    step('1, 1, 3'd0, 8'hFF);
    for (int c = 0; c < 5; c++) step('1, 0, 3'd0, 0);
    // random phase
    pins = '1;
    for (int c = 0; c < 4000; c++) begin
      bit w;
      for (int i = 0; i < N; i++)
        if ($urandom_range(3) == 0) pins[i] = ~pins[i];
      w = ($urandom_range(9) < 2);
      step(pins, w, AW'($urandom_range(7)), 8'($urandom));
    end
    for (int c = 0; c < 5; c++) step(pins, 0, 3'd0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule